// File: doc/BRIEF.md
# Four-Level Priority Bus Arbiter

This block is a central arbiter for a shared bus with between two and sixteen masters. Each master raises a request and drives a two-bit level code with it. The arbiter picks the highest level among the current requesters and returns a registered one-hot grant. A tie at the winning level goes to the lowest index, or to the next master in rotating order, depending on a mode input.

A granted master keeps the bus until the bus signals that its transfer has finished. The arbiter then arbitrates again. A master in a long burst can still hold up urgent traffic, so a countdown timer bounds its tenure. The timer reloads from a programmable limit each time a grant is awarded. It counts down on every cycle in which the owner reports an active burst. Once the count reaches zero, any requester at a strictly higher level than the owner's winning level takes the bus at the next edge.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the grant vector is all zeros.
- R2: The grant vector has at most one bit set. When no master requests and nobody holds the bus, the grant stays all zeros.
- R3: Level code 3 is the highest and 0 the lowest. Each award goes to a requester whose level equals the maximum level among all current requesters. The grant shows on the cycle after the clock edge where the award is made.
- R4: With the mode input low, a tie at the winning level goes to the tied master with the lowest index.
- R5: With the mode input high, a tie goes to the first tied master found by scanning upward, with wrap-around, from a pointer. Every award, in either mode, moves the pointer to the index after the winner (index 0 after the last master). Reset sets the pointer to 0.
- R6: A granted master keeps the grant while the transfer-end input is low and no preemption occurs. This holds even if it drops its request or changes its level.
- R7: Every award with at least one requester loads the burst timer with the limit input. On any other cycle the timer decrements by one while the owner's burst-active bit is high, and it stops at zero.
- R8: When the timer is zero and a requester exists at a level strictly above the owner's winning level, the bus is re-awarded at the next edge by the R3 to R5 rules. A requester at an equal or lower level never preempts.
- R9: When transfer-end is high at an edge, the bus is re-awarded among the current requesters, the owner included. With no requesters, the grant clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Request, one bit per master |
| prio | input | 2*N_MASTERS | Level code per master, master i at bits [2i+1:2i] |
| rr_mode | input | 1 | Tie-break select: 0 lowest index, 1 rotating |
| burst_limit | input | LIMIT_W | Cycle budget loaded into the burst timer on each award |
| burst_act | input | N_MASTERS | Burst-active flag, one bit per master |
| xfer_done | input | 1 | End of the current owner's transfer |
| grant | output | N_MASTERS | Registered one-hot grant |

## Verification
The bench builds the arbiter with five masters and a four-bit limit. With five masters, the rotating pointer has to wrap from index 4 back to 0 without a power-of-two modulus. The four-bit limit lets limits of zero to seven make a burst expire within a few cycles, so random traffic reaches preemption often. Limit zero makes an owner open to preemption on the cycle it is granted. Directed runs cover a waiting higher master held off until expiry, and equal-level requesters that never preempt.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef logic [1:0] level_t;

    typedef enum logic {
        TIE_FIXED = 1'b0,
        TIE_ROUND = 1'b1
    } tie_mode_e;

    localparam int LEVEL_BITS = 2;

    // index of the slot after i in a ring of n slots
    function automatic int unsigned ring_next(input int unsigned i, input int unsigned n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

endpackage

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [N_MASTERS-1:0]            req,
    input  logic [LEVEL_BITS*N_MASTERS-1:0] prio,
    input  tie_mode_e                       mode,
    input  logic [IDX_W-1:0]                ptr,
    output logic                            any_req,
    output level_t                          top_lvl,
    output logic [IDX_W-1:0]                win_idx
);

    logic [N_MASTERS-1:0] tied;

    // highest requesting level
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (req[i] && (prio[i*LEVEL_BITS +: LEVEL_BITS] > top_lvl))
                top_lvl = prio[i*LEVEL_BITS +: LEVEL_BITS];
        end
    end

    generate
        for (genvar g = 0; g < N_MASTERS; g++) begin : g_tie
            assign tied[g] = req[g] && (prio[g*LEVEL_BITS +: LEVEL_BITS] == top_lvl);
        end
    endgenerate

    assign any_req = |req;

    // choose one member of the tied set
    always_comb begin
        int  idx;
        logic found;
        win_idx = '0;
        found   = 1'b0;
        idx     = 0;
        if (mode == TIE_FIXED) begin
            for (int i = 0; i < N_MASTERS; i++) begin
                if (tied[i] && !found) begin
                    win_idx = IDX_W'(i);
                    found   = 1'b1;
                end
            end
        end else begin
            for (int k = 0; k < N_MASTERS; k++) begin
                idx = int'(ptr) + k;
                if (idx >= N_MASTERS) idx = idx - N_MASTERS;
                if (tied[idx] && !found) begin
                    win_idx = IDX_W'(idx);
                    found   = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/burst_timer.sv
module burst_timer #(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               active,
    output logic               expired
);

    logic [LIMIT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= limit;
        end else if (active && (count_q != '0)) begin
            count_q <= count_q - LIMIT_W'(1);
        end
    end

    assign expired = (count_q == '0);

    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (count_q == $past(limit)));

    assert_count_down_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && active && (count_q != '0)) |=> (count_q == $past(count_q) - LIMIT_W'(1)));

    assert_floor_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && (count_q == '0)) |=> (count_q == '0));

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int LIMIT_W   = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_MASTERS-1:0]            req,
    input  logic [LEVEL_BITS*N_MASTERS-1:0] prio,
    input  logic                            rr_mode,
    input  logic [LIMIT_W-1:0]              burst_limit,
    input  logic [N_MASTERS-1:0]            burst_act,
    input  logic                            xfer_done,
    output logic [N_MASTERS-1:0]            grant
);

    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    initial begin
        assert (N_MASTERS >= 2 && N_MASTERS <= 16);
    end

    logic [N_MASTERS-1:0] grant_q;
    level_t               owner_lvl_q;
    logic [IDX_W-1:0]     rr_ptr_q;

    logic                 any_req;
    level_t               top_lvl;
    logic [IDX_W-1:0]     win_idx;
    logic                 expired;
    logic                 higher_waiting;
    logic                 preempt;
    logic                 award;
    logic                 owner_busy;
    logic [IDX_W-1:0]     next_ptr;

    arb_pick #(
        .N_MASTERS (N_MASTERS),
        .IDX_W     (IDX_W)
    ) u_pick (
        .req     (req),
        .prio    (prio),
        .mode    (tie_mode_e'(rr_mode)),
        .ptr     (rr_ptr_q),
        .any_req (any_req),
        .top_lvl (top_lvl),
        .win_idx (win_idx)
    );

    assign owner_busy = |(burst_act & grant_q);

    burst_timer #(
        .LIMIT_W (LIMIT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (award && any_req),
        .limit   (burst_limit),
        .active  (owner_busy),
        .expired (expired)
    );

    assign higher_waiting = (grant_q != '0) && any_req && (top_lvl > owner_lvl_q);
    assign preempt        = expired && higher_waiting;
    assign award          = (grant_q == '0) || xfer_done || preempt;
    assign next_ptr       = IDX_W'(ring_next(int'(win_idx), N_MASTERS));

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q     <= '0;
            owner_lvl_q <= '0;
            rr_ptr_q    <= '0;
        end else if (award) begin
            if (any_req) begin
                grant_q     <= N_MASTERS'(1) << win_idx;
                owner_lvl_q <= top_lvl;
                rr_ptr_q    <= next_ptr;
            end else begin
                grant_q <= '0;
            end
        end
    end

    assign grant = grant_q;

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q));

    assert_stay_idle_R2: assert property (@(posedge clk) disable iff (rst)
        ((req == '0) && (grant_q == '0)) |=> (grant_q == '0));

    assert_winner_requested_R3: assert property (@(posedge clk) disable iff (rst)
        (award && (req != '0)) |=> ((grant_q & $past(req)) != '0));

    assert_keep_owner_R6: assert property (@(posedge clk) disable iff (rst)
        ((grant_q != '0) && !xfer_done && !preempt) |=> $stable(grant_q));

    assert_preempt_raises_R8: assert property (@(posedge clk) disable iff (rst)
        preempt |=> (owner_lvl_q > $past(owner_lvl_q)));

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && (req == '0)) |=> (grant_q == '0));

endmodule

// File: tb/prio_bus_arbiter_bench.sv
`timescale 1ns/1ps
module prio_bus_arbiter_bench;

    localparam int N  = 5;
    localparam int LW = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    req;
    logic [2*N-1:0]  prio;
    logic            rr_mode;
    logic [LW-1:0]   burst_limit;
    logic [N-1:0]    burst_act;
    logic            xfer_done;
    logic [N-1:0]    grant;

    int total = 0;
    int fails = 0;

    // reference state
    int m_own;
    int m_lvl;
    int m_ptr;
    int m_cnt;

    always #10 clk = ~clk;

    prio_bus_arbiter #(.N_MASTERS(N), .LIMIT_W(LW)) u_prio_bus_arbiter (
        .clk(clk), .rst(rst), .req(req), .prio(prio), .rr_mode(rr_mode),
        .burst_limit(burst_limit), .burst_act(burst_act),
        .xfer_done(xfer_done), .grant(grant)
    );

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: grant actual %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] exp_vec();
        return (m_own < 0) ? '0 : (N'(1) << m_own);
    endfunction

    function automatic int lvl_of(input logic [2*N-1:0] p, input int i);
        return int'(p[2*i +: 2]);
    endfunction

    // advance the reference by one edge, using the inputs now applied
    task automatic model_edge();
        int top;
        int win;
        int idx;
        bit any;
        bit pre;
        bit awd;
        top = 0; win = -1; any = (req != '0);
        for (int i = 0; i < N; i++)
            if (req[i] && lvl_of(prio, i) > top) top = lvl_of(prio, i);
        if (!rr_mode) begin
            for (int i = N - 1; i >= 0; i--)
                if (req[i] && lvl_of(prio, i) == top) win = i;
        end else begin
            for (int k = N - 1; k >= 0; k--) begin
                idx = (m_ptr + k) % N;
                if (req[idx] && lvl_of(prio, idx) == top) win = idx;
            end
        end
        pre = (m_own >= 0) && (m_cnt == 0) && any && (top > m_lvl);
        awd = (m_own < 0) || xfer_done || pre;
        if (awd && any) begin
            m_cnt = int'(burst_limit);
        end else if (m_own >= 0 && burst_act[m_own] && m_cnt > 0) begin
            m_cnt = m_cnt - 1;
        end
        if (awd) begin
            if (any) begin
                m_own = win; m_lvl = top; m_ptr = (win + 1) % N;
            end else begin
                m_own = -1;
            end
        end
    endtask

    task automatic cyc(input logic [N-1:0] r, input logic [2*N-1:0] p, input logic mode,
                       input logic [LW-1:0] lim, input logic [N-1:0] act, input logic done,
                       input string tag);
        @(negedge clk);
        req = r; prio = p; rr_mode = mode; burst_limit = lim;
        burst_act = act; xfer_done = done;
        model_edge();
        @(posedge clk);
        #1;
        check(tag, grant, exp_vec());
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = '0; prio = '0; rr_mode = 1'b0;
        burst_limit = '0; burst_act = '0; xfer_done = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 during reset", grant, '0);
        @(negedge clk);
        rst = 1'b0;
        m_own = -1; m_lvl = 0; m_ptr = 0; m_cnt = 0;
    endtask

    // level codes, master 0 in the low bits
    function automatic logic [2*N-1:0] lv(input int a, input int b, input int c, input int d, input int e);
        return {2'(e), 2'(d), 2'(c), 2'(b), 2'(a)};
    endfunction

    initial begin
        #(200000 * 20);
        fails++; total++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();
        // R1 first cycle after reset, nobody asking
        cyc('0, '0, 1'b0, 4'd3, '0, 1'b0, "R1 after reset");
        check("R1 literal", grant, 5'b00000);
        // R2 idle stays idle
        repeat (3) cyc('0, lv(3,3,3,3,3), 1'b1, 4'd3, '1, 1'b1, "R2 idle");

        // R3 highest level wins
        cyc(5'b01010, lv(0,1,0,2,0), 1'b0, 4'd9, '0, 1'b0, "R3 top level");
        check("R3 literal", grant, 5'b01000);

        // R4 fixed tie, lowest index
        cyc(5'b10100, lv(0,0,2,0,2), 1'b0, 4'd9, '0, 1'b1, "R4 fixed tie");
        check("R4 literal", grant, 5'b00100);

        // R5 rotating tie among all five at level 1, wraps past 4
        do_reset();
        for (int k = 0; k < 7; k++)
            cyc(5'b11111, lv(1,1,1,1,1), 1'b1, 4'd9, '0, 1'b1, "R5 rotate");
        check("R5 literal", grant, 5'b00010);

        // R6 owner keeps bus while higher waits and timer still running
        do_reset();
        cyc(5'b00001, lv(0,0,0,0,0), 1'b0, 4'd15, '1, 1'b0, "R6 grant m0");
        for (int k = 0; k < 5; k++)
            cyc(5'b10000, lv(0,0,0,0,3), 1'b0, 4'd15, '1, 1'b0, "R6 hold");
        check("R6 literal", grant, 5'b00001);

        // R7 R8 expiry after two burst cycles, then preempt
        do_reset();
        cyc(5'b00001, lv(0,0,0,0,0), 1'b0, 4'd2, 5'b00001, 1'b0, "R7 load");
        cyc(5'b10001, lv(0,0,0,0,3), 1'b0, 4'd2, 5'b00001, 1'b0, "R7 count 1");
        cyc(5'b10001, lv(0,0,0,0,3), 1'b0, 4'd2, 5'b00001, 1'b0, "R7 count 0");
        check("R7 literal still m0", grant, 5'b00001);
        cyc(5'b10001, lv(0,0,0,0,3), 1'b0, 4'd2, 5'b00001, 1'b0, "R8 preempt");
        check("R8 literal", grant, 5'b10000);

        // R8 equal level never preempts an expired owner
        do_reset();
        cyc(5'b00010, lv(0,2,0,0,0), 1'b0, 4'd0, '1, 1'b0, "R8 grant m1");
        for (int k = 0; k < 4; k++)
            cyc(5'b00111, lv(2,2,2,0,0), 1'b0, 4'd0, '1, 1'b0, "R8 equal level");
        check("R8 literal equal", grant, 5'b00010);

        // R9 end of transfer with no requests clears
        cyc('0, '0, 1'b0, 4'd0, '0, 1'b1, "R9 release");
        check("R9 literal", grant, 5'b00000);

        // constrained random traffic
        do_reset();
        begin
            int unused;
            unused = $urandom(32'd1234);
        end
        for (int ph = 0; ph < 20; ph++) begin
            logic             mode;
            logic [LW-1:0]    lim;
            mode = ph[0];
            lim  = LW'($urandom_range(0, 7));
            for (int k = 0; k < 250; k++) begin
                cyc(N'($urandom), 10'($urandom), mode, lim,
                    N'($urandom | $urandom), ($urandom_range(0, 5) == 0),
                    "R3 R4 R5 R6 R7 R8 R9 random");
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule